// File: doc/BRIEF.md
# PCIe Bridge Interrupt Aggregator

This block gathers the interrupt sources of a PCIe root-port bridge into a single line towards the host processor. Four legacy INTx level inputs arrive from the link side. Inbound MSI memory writes are seen as an address/data strobe. A write to one fixed doorbell address with data `n` marks MSI vector `n` pending.

Software works through a 32-bit register port. It can read a local status word, a local mask word and a 32-bit MSI pending word. Both status words are write-one-to-clear. All 32 MSI vectors fold into one summary bit of the local status word, which sits next to the four INTx bits. The combined interrupt output is high while any local status bit is set and also enabled in the mask. A handler that reads the local status word as zero knows the interrupt came from another source.

Top module: `pcie_irq_agg`

## Requirements
- R1: The local mask register at offset 0x180 is read/write. Only bits 28:24 are stored, and every other bit reads as 0. It resets to 0.
- R2: A rising edge on `intx_in[i]` sets local status bit 24+i, so INTA is bit 24 and INTD is bit 27. The bit stays set after the input falls. A level held high does not set it again once it has been cleared.
- R3: Writing 1 to a bit of the local status register at 0x184 clears that bit. Writing 0 leaves the bit unchanged, and writing all ones clears every bit.
- R4: An inbound write to doorbell address 0x190 with data n < 32 sets bit n of the MSI status register at 0x194. It also sets summary bit 28 of the local status register, and both are visible in the next cycle.
- R5: An inbound write with data of 32 or more changes nothing. So does an inbound write to any address other than 0x190.
- R6: Writing 1 to a bit of the MSI status register clears that bit. Writing 0 leaves the bit unchanged.
- R7: If the summary bit is cleared while the MSI status register is still nonzero, the summary bit reads 0 for one cycle and is then set again.
- R8: When a new INTx rising edge or MSI arrives in the same cycle as a write-one-to-clear of the same bit, the bit stays set.
- R9: `irq_out` is high exactly when (local status AND local mask) is nonzero.
- R10: After reset every status bit is 0 and `irq_out` is low. Reads of unmapped offsets, including 0x188 and 0x18C, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_in | input | 4 | INTA..INTD levels from the link side |
| msi_wr_en | input | 1 | Inbound memory-write strobe |
| msi_wr_addr | input | 12 | Inbound write address offset |
| msi_wr_data | input | 32 | Inbound write data (MSI vector number) |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 12 | Register offset, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
Two functions can fall in the same cycle: a new event (an INTx rising edge or a doorbell write) and a software write-one-to-clear that targets the same status bit. The bench provokes this by driving both on one clock edge. It first does so for INTD, then for MSI vector 7, and expects the bit to read back as set. A second clear, made while the INTx level is still high, must then leave the bit at 0. The re-arming summary bit is a related case, where a summary clear meets a nonzero MSI word. The bench judges it by reading the local status word on the two cycles that follow the clear.

// File: rtl/pcie_irq_agg_pkg.sv
package pcie_irq_agg_pkg;

   // register offsets inside the bridge window
   localparam logic [11:0] DEF_LMASK_OFF = 12'h180;
   localparam logic [11:0] DEF_LSTAT_OFF = 12'h184;
   localparam logic [11:0] DEF_DBELL_OFF = 12'h190;
   localparam logic [11:0] DEF_MSTAT_OFF = 12'h194;

   // field placement in the local words
   localparam int unsigned DEF_INTX_LSB = 24;
   localparam int unsigned DEF_SUM_POS  = 28;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_LMASK = 2'd1,
      SEL_LSTAT = 2'd2,
      SEL_MSTAT = 2'd3
   } agg_sel_e;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int unsigned N    = 4,
   parameter bit          SYNC = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_in,
   input  logic [N-1:0] clr,
   output logic [N-1:0] stat
);

   logic [N-1:0] lvl_s;

   generate
      if (SYNC) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) lvl_s <= '0;
            else        lvl_s <= lvl_in;
         end
      end else begin : g_direct
         assign lvl_s = lvl_in;
      end
   endgenerate

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      logic stat_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
         end else begin
            prev_q <= lvl_s[i];
            // a fresh edge wins over a clear in the same cycle
            stat_q <= (stat_q & ~clr[i]) | (lvl_s[i] & ~prev_q);
         end
      end
      assign stat[i] = stat_q;
   end

endmodule

// File: rtl/irq_msi_pend.sv
module irq_msi_pend #(
   parameter int unsigned N_MSI = 32,
   localparam int unsigned VEC_W = $clog2(N_MSI)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [VEC_W-1:0] vec,
   input  logic [N_MSI-1:0] clr,
   input  logic             sum_clr,
   output logic [N_MSI-1:0] pend,
   output logic             sum
);

   logic [N_MSI-1:0] set_vec;
   logic [N_MSI-1:0] pend_q;
   logic             sum_q;

   assign set_vec = hit ? (N_MSI'(1) << vec) : '0;

   for (genvar i = 0; i < N_MSI; i++) begin : g_vec
      always_ff @(posedge clk) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else        pend_q[i] <= (pend_q[i] & ~clr[i]) | set_vec[i];
      end
   end

   // summary: set by a new vector, re-armed while any vector is pending
   always_ff @(posedge clk) begin
      if (!rst_n) sum_q <= 1'b0;
      else        sum_q <= (|set_vec) | (~sum_clr & (sum_q | (|pend_q)));
   end

   assign pend = pend_q;
   assign sum  = sum_q;

endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
   import pcie_irq_agg_pkg::*;
#(
   parameter int unsigned REG_AW   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned N_INTX   = 4,
   parameter int unsigned N_MSI    = 32,
   parameter int unsigned INTX_LSB = 24,
   parameter int unsigned SUM_POS  = 28,
   parameter logic [REG_AW-1:0] LMASK_OFF = REG_AW'(DEF_LMASK_OFF),
   parameter logic [REG_AW-1:0] LSTAT_OFF = REG_AW'(DEF_LSTAT_OFF),
   parameter logic [REG_AW-1:0] DBELL_OFF = REG_AW'(DEF_DBELL_OFF),
   parameter logic [REG_AW-1:0] MSTAT_OFF = REG_AW'(DEF_MSTAT_OFF),
   localparam int unsigned VEC_W = $clog2(N_MSI)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_INTX-1:0] intx_stat,
   input  logic              sum_stat,
   input  logic [N_MSI-1:0]  msi_stat,
   output logic [N_INTX-1:0] intx_mask,
   output logic              sum_mask,
   output logic [N_INTX-1:0] intx_clr,
   output logic              sum_clr,
   output logic [N_MSI-1:0]  msi_clr,
   input  logic              msi_wr_en,
   input  logic [REG_AW-1:0] msi_wr_addr,
   input  logic [DATA_W-1:0] msi_wr_data,
   output logic              msi_hit,
   output logic [VEC_W-1:0]  msi_vec
);

   agg_sel_e          sel;
   logic [N_INTX:0]   mask_q;
   logic              wr_lstat;
   logic              wr_mstat;

   always_comb begin
      if      (reg_addr == LMASK_OFF) sel = SEL_LMASK;
      else if (reg_addr == LSTAT_OFF) sel = SEL_LSTAT;
      else if (reg_addr == MSTAT_OFF) sel = SEL_MSTAT;
      else                            sel = SEL_NONE;
   end

   // mask storage: only the defined source positions exist
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (reg_we && sel == SEL_LMASK) begin
         mask_q <= {reg_wdata[SUM_POS], reg_wdata[INTX_LSB +: N_INTX]};
      end
   end

   assign intx_mask = mask_q[N_INTX-1:0];
   assign sum_mask  = mask_q[N_INTX];

   // write-one-to-clear strobes
   assign wr_lstat = reg_we && (sel == SEL_LSTAT);
   assign wr_mstat = reg_we && (sel == SEL_MSTAT);
   assign intx_clr = wr_lstat ? reg_wdata[INTX_LSB +: N_INTX] : '0;
   assign sum_clr  = wr_lstat & reg_wdata[SUM_POS];
   assign msi_clr  = wr_mstat ? reg_wdata[N_MSI-1:0] : '0;

   // inbound doorbell decode; out-of-range vector numbers are dropped
   assign msi_hit = msi_wr_en && (msi_wr_addr == DBELL_OFF) &&
                    (msi_wr_data < DATA_W'(N_MSI));
   assign msi_vec = msi_wr_data[VEC_W-1:0];

   // read mux
   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_LMASK: begin
            reg_rdata[INTX_LSB +: N_INTX] = intx_mask;
            reg_rdata[SUM_POS]            = sum_mask;
         end
         SEL_LSTAT: begin
            reg_rdata[INTX_LSB +: N_INTX] = intx_stat;
            reg_rdata[SUM_POS]            = sum_stat;
         end
         SEL_MSTAT: reg_rdata[N_MSI-1:0] = msi_stat;
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pcie_irq_agg.sv
module pcie_irq_agg
   import pcie_irq_agg_pkg::*;
#(
   parameter int unsigned REG_AW    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned N_INTX    = 4,
   parameter int unsigned N_MSI     = 32,
   parameter int unsigned INTX_LSB  = DEF_INTX_LSB,
   parameter int unsigned SUM_POS   = DEF_SUM_POS,
   parameter bit          INTX_SYNC = 1'b0,
   parameter logic [REG_AW-1:0] LMASK_OFF = REG_AW'(DEF_LMASK_OFF),
   parameter logic [REG_AW-1:0] LSTAT_OFF = REG_AW'(DEF_LSTAT_OFF),
   parameter logic [REG_AW-1:0] DBELL_OFF = REG_AW'(DEF_DBELL_OFF),
   parameter logic [REG_AW-1:0] MSTAT_OFF = REG_AW'(DEF_MSTAT_OFF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_INTX-1:0] intx_in,
   input  logic              msi_wr_en,
   input  logic [REG_AW-1:0] msi_wr_addr,
   input  logic [DATA_W-1:0] msi_wr_data,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);

   localparam int unsigned VEC_W = $clog2(N_MSI);

   // elaboration-time parameter checks
   if (N_MSI > DATA_W || N_MSI < 2) begin : g_bad_nmsi
      $error("N_MSI must be between 2 and DATA_W");
   end
   if ((1 << VEC_W) != N_MSI) begin : g_bad_pow2
      $error("N_MSI must be a power of two");
   end
   if (INTX_LSB + N_INTX > DATA_W || SUM_POS >= DATA_W) begin : g_bad_place
      $error("INTx or summary field lies outside the data word");
   end
   if (SUM_POS >= INTX_LSB && SUM_POS < INTX_LSB + N_INTX) begin : g_bad_ovl
      $error("summary bit overlaps the INTx field");
   end

   logic [N_INTX-1:0] intx_stat, intx_mask, intx_clr;
   logic              sum_stat, sum_mask, sum_clr;
   logic [N_MSI-1:0]  msi_stat, msi_clr;
   logic              msi_hit;
   logic [VEC_W-1:0]  msi_vec;
   logic [DATA_W-1:0] loc_stat_w, loc_mask_w;

   irq_reg_if #(
      .REG_AW(REG_AW), .DATA_W(DATA_W), .N_INTX(N_INTX), .N_MSI(N_MSI),
      .INTX_LSB(INTX_LSB), .SUM_POS(SUM_POS),
      .LMASK_OFF(LMASK_OFF), .LSTAT_OFF(LSTAT_OFF),
      .DBELL_OFF(DBELL_OFF), .MSTAT_OFF(MSTAT_OFF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .intx_stat(intx_stat), .sum_stat(sum_stat), .msi_stat(msi_stat),
      .intx_mask(intx_mask), .sum_mask(sum_mask),
      .intx_clr(intx_clr), .sum_clr(sum_clr), .msi_clr(msi_clr),
      .msi_wr_en(msi_wr_en), .msi_wr_addr(msi_wr_addr),
      .msi_wr_data(msi_wr_data),
      .msi_hit(msi_hit), .msi_vec(msi_vec)
   );

   irq_edge_latch #(.N(N_INTX), .SYNC(INTX_SYNC)) u_intx (
      .clk(clk), .rst_n(rst_n),
      .lvl_in(intx_in), .clr(intx_clr), .stat(intx_stat)
   );

   irq_msi_pend #(.N_MSI(N_MSI)) u_msi (
      .clk(clk), .rst_n(rst_n),
      .hit(msi_hit), .vec(msi_vec), .clr(msi_clr), .sum_clr(sum_clr),
      .pend(msi_stat), .sum(sum_stat)
   );

   always_comb begin
      loc_stat_w = '0;
      loc_stat_w[INTX_LSB +: N_INTX] = intx_stat;
      loc_stat_w[SUM_POS]            = sum_stat;
      loc_mask_w = '0;
      loc_mask_w[INTX_LSB +: N_INTX] = intx_mask;
      loc_mask_w[SUM_POS]            = sum_mask;
   end

   assign irq_out = |(loc_stat_w & loc_mask_w);

endmodule

// File: rtl/pcie_irq_agg_chk.sv
module pcie_irq_agg_chk #(
   parameter int unsigned REG_AW   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned N_INTX   = 4,
   parameter int unsigned N_MSI    = 32,
   parameter int unsigned INTX_LSB = 24,
   parameter int unsigned SUM_POS  = 28,
   parameter logic [REG_AW-1:0] LSTAT_OFF = 12'h184,
   parameter logic [REG_AW-1:0] DBELL_OFF = 12'h190,
   parameter logic [REG_AW-1:0] MSTAT_OFF = 12'h194
) (
   input logic              clk,
   input logic              rst_n,
   input logic              msi_wr_en,
   input logic [REG_AW-1:0] msi_wr_addr,
   input logic [DATA_W-1:0] msi_wr_data,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              irq_out,
   input logic [DATA_W-1:0] loc_stat,
   input logic [DATA_W-1:0] loc_mask,
   input logic [N_MSI-1:0]  msi_stat
);

   localparam int unsigned VEC_W = $clog2(N_MSI);

   logic db_ok;
   assign db_ok = msi_wr_en && (msi_wr_addr == DBELL_OFF) &&
                  (msi_wr_data < DATA_W'(N_MSI));

   AST_MSI_SETS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      db_ok |=> ((msi_stat & (N_MSI'(1) << $past(msi_wr_data[VEC_W-1:0]))) != '0)); // R4

   AST_MSI_SETS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      db_ok |=> loc_stat[SUM_POS]); // R4

   AST_MSI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && !db_ok) |=> $stable(msi_stat)); // R5

   AST_MSI_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == MSTAT_OFF && !msi_wr_en)
      |=> ((msi_stat & $past(reg_wdata[N_MSI-1:0])) == '0)); // R6

   AST_SUM_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!loc_stat[SUM_POS] && msi_stat != '0) |=> loc_stat[SUM_POS]); // R7

   AST_SUM_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == LSTAT_OFF && reg_wdata[SUM_POS] &&
       msi_stat == '0 && !msi_wr_en) |=> !loc_stat[SUM_POS]); // R3

   AST_INTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == LSTAT_OFF)
      |=> (($past(loc_stat[INTX_LSB +: N_INTX]) & ~loc_stat[INTX_LSB +: N_INTX]) == '0)); // R2

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_mask == '0) |-> !irq_out); // R9

endmodule

bind pcie_irq_agg pcie_irq_agg_chk #(
   .REG_AW(REG_AW), .DATA_W(DATA_W), .N_INTX(N_INTX), .N_MSI(N_MSI),
   .INTX_LSB(INTX_LSB), .SUM_POS(SUM_POS),
   .LSTAT_OFF(LSTAT_OFF), .DBELL_OFF(DBELL_OFF), .MSTAT_OFF(MSTAT_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .msi_wr_en(msi_wr_en), .msi_wr_addr(msi_wr_addr), .msi_wr_data(msi_wr_data),
   .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .irq_out(irq_out),
   .loc_stat(loc_stat_w), .loc_mask(loc_mask_w), .msi_stat(msi_stat)
);

// File: tb/pcie_irq_agg_bench.sv
module pcie_irq_agg_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  intx_in = '0;
   logic        msi_wr_en = 1'b0;
   logic [11:0] msi_wr_addr = '0;
   logic [31:0] msi_wr_data = '0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   typedef struct {
      logic [11:0] addr;
      logic [31:0] data;
      logic        irq;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;

   always #5 clk = ~clk;

   pcie_irq_agg u_pcie_irq_agg (
      .clk(clk), .rst_n(rst_n), .intx_in(intx_in),
      .msi_wr_en(msi_wr_en), .msi_wr_addr(msi_wr_addr), .msi_wr_data(msi_wr_data),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   // monitor: pops one expected item per cycle, samples away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (reg_rdata !== e.data || irq_out !== e.irq) begin
               bad++;
               $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                        e.tag, e.addr, reg_rdata, irq_out, e.data, e.irq);
            end
         end
      end
   end

   // driver tasks: entered just after a falling edge, leave at the next one
   task automatic expect_rd(input logic [11:0] a, input logic [31:0] d,
                            input logic irq, input string tag);
      exp_t e;
      reg_addr = a;
      e.addr = a; e.data = d; e.irq = irq; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic msi(input logic [11:0] a, input logic [31:0] d);
      msi_wr_en = 1'b1; msi_wr_addr = a; msi_wr_data = d;
      @(negedge clk);
      msi_wr_en = 1'b0; msi_wr_addr = '0; msi_wr_data = '0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state and unmapped offsets
      expect_rd(12'h180, 32'h0, 1'b0, "R10 mask after reset");
      expect_rd(12'h184, 32'h0, 1'b0, "R10 local status after reset");
      expect_rd(12'h194, 32'h0, 1'b0, "R10 msi status after reset");
      expect_rd(12'h188, 32'h0, 1'b0, "R10 unmapped 0x188");
      expect_rd(12'h18C, 32'h0, 1'b0, "R10 unmapped 0x18C");

      // R1: only bits 28:24 of the mask are kept
      wr(12'h180, 32'hFFFF_FFFF);
      expect_rd(12'h180, 32'h1F00_0000, 1'b0, "R1 mask all ones");
      wr(12'h180, 32'h0);
      expect_rd(12'h180, 32'h0, 1'b0, "R1 mask cleared");

      // R2: INTA and INTC rising edges latch and hold
      intx_in = 4'b0101;
      @(negedge clk);
      expect_rd(12'h184, 32'h0500_0000, 1'b0, "R2 INTA/INTC latched");
      intx_in = 4'b0000;
      @(negedge clk);
      expect_rd(12'h184, 32'h0500_0000, 1'b0, "R2 held after input falls");

      // R9: output follows status AND mask
      wr(12'h180, 32'h0100_0000);
      expect_rd(12'h184, 32'h0500_0000, 1'b1, "R9 INTA enabled");
      wr(12'h180, 32'h0200_0000);
      expect_rd(12'h184, 32'h0500_0000, 1'b0, "R9 INTB enabled, not pending");

      // R3: write-one-to-clear on local status
      wr(12'h184, 32'h0);
      expect_rd(12'h184, 32'h0500_0000, 1'b0, "R3 writing zero keeps bits");
      wr(12'h184, 32'h0100_0000);
      expect_rd(12'h184, 32'h0400_0000, 1'b0, "R3 INTA cleared only");
      wr(12'h180, 32'h0400_0000);
      expect_rd(12'h184, 32'h0400_0000, 1'b1, "R9 INTC enabled");
      wr(12'h184, 32'hFFFF_FFFF);
      expect_rd(12'h184, 32'h0, 1'b0, "R3 all ones clears all");

      // R4: doorbell sets vector and summary
      msi(12'h190, 32'd5);
      expect_rd(12'h194, 32'h0000_0020, 1'b0, "R4 vector 5");
      expect_rd(12'h184, 32'h1000_0000, 1'b0, "R4 summary set");
      wr(12'h180, 32'h1000_0000);
      expect_rd(12'h184, 32'h1000_0000, 1'b1, "R9 summary enabled");
      msi(12'h190, 32'd31);
      msi(12'h190, 32'd0);
      expect_rd(12'h194, 32'h8000_0021, 1'b1, "R4 vectors 0 and 31");

      // R5: out-of-range data and wrong address are dropped
      msi(12'h190, 32'd32);
      msi(12'h190, 32'hFFFF_FFFF);
      msi(12'h194, 32'd3);
      expect_rd(12'h194, 32'h8000_0021, 1'b1, "R5 ignored inbound writes");

      // R6: write-one-to-clear on MSI status
      wr(12'h194, 32'h0000_0020);
      expect_rd(12'h194, 32'h8000_0001, 1'b1, "R6 vector 5 cleared");

      // R7: summary clear with vectors still pending re-arms one cycle later
      wr(12'h184, 32'h1000_0000);
      expect_rd(12'h184, 32'h0, 1'b0, "R7 summary low right after clear");
      expect_rd(12'h184, 32'h1000_0000, 1'b1, "R7 summary re-armed");
      wr(12'h194, 32'hFFFF_FFFF);
      expect_rd(12'h194, 32'h0, 1'b1, "R6 all vectors cleared");
      wr(12'h184, 32'h1000_0000);
      expect_rd(12'h184, 32'h0, 1'b0, "R7 summary stays low, nothing pending");
      expect_rd(12'h184, 32'h0, 1'b0, "R7 no re-arm");

      // R8: new INTD edge in the same cycle as its clear
      intx_in = 4'b1000;
      wr(12'h184, 32'h0800_0000);
      expect_rd(12'h184, 32'h0800_0000, 1'b0, "R8 INTD edge beats clear");
      wr(12'h184, 32'h0800_0000);
      expect_rd(12'h184, 32'h0, 1'b0, "R2 held level does not set again");
      intx_in = 4'b0000;

      // R8: new MSI in the same cycle as its clear
      msi(12'h190, 32'd7);
      msi_wr_en = 1'b1; msi_wr_addr = 12'h190; msi_wr_data = 32'd7;
      wr(12'h194, 32'h0000_0080);
      msi_wr_en = 1'b0; msi_wr_addr = '0; msi_wr_data = '0;
      expect_rd(12'h194, 32'h0000_0080, 1'b1, "R8 MSI beats clear");

      @(negedge clk);
      wait (exp_q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      finish_run();
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_run();
      end
   end

endmodule